// File: doc/BRIEF.md
# Page-Translated DMA Engine

This block serves one DMA channel. Software programs a logical start address, a byte count, a page-table base and an enable word through a small register file. A device then requests a transfer of a given length in one direction. The engine walks the logical range and looks up each logical 4 KiB page in a table held in memory. It joins the physical page from the table entry to the in-page offset and moves bytes between the device byte stream and physical memory. A single memory master port carries both the 32-bit table-entry reads and the byte-wide data accesses.

The transfer is split into chunks. Each chunk starts with a table lookup. A chunk is 256 bytes when the physical address is 256-byte aligned and enough bytes remain, 16 bytes when it is 16-byte aligned and enough remain, and 1 byte otherwise. A chunk never crosses a page, so every page crossing brings a fresh lookup. A request is refused when the run flag is clear or when its direction disagrees with the direction flag. When a transfer completes, the count register is cleared and a done pulse is raised.

Top module: `pdma_engine`

## Requirements
- R1: Five 32-bit registers are selected by `reg_addr`: 0 mode, 1 enable, 2 count, 3 logical start address, 4 table base. Each reads back the last value written and is zero after reset. Any other index reads as zero.
- R2: Enable bit 0 is the run flag. Enable bit 1 set means device-bound (memory is read). Bit 1 clear means memory-bound (memory is written). A start with the run flag clear, or with `start_to_mem` equal to bit 1, raises `err` for one cycle. Such a start makes no memory access, moves no byte, keeps `busy` low and leaves the count register unchanged.
- R3: The table entry for logical address L is read as a 32-bit access (`mem_word`=1, `mem_we`=0) at table_base + (L>>12)*8. `mem_rdata[7:0]` is the byte at the lowest address. With `entry_big_endian`=1 that byte is the most significant byte of the entry. With it at 0, that byte is the least significant.
- R4: The physical address of a byte is the entry with its low 12 bits cleared, plus the low 12 bits of its logical address.
- R5: Bytes are moved at logical addresses start, start+1, and so on, only while the address is below start+count and fewer than `start_len` bytes have been moved. A zero count or zero length moves nothing.
- R6: A lookup precedes every chunk. With rem = min(bytes left, start+count minus address), the chunk is 256 bytes if the physical address is 256-aligned and rem>=256. Otherwise it is 16 bytes if the address is 16-aligned and rem>=16. Otherwise it is 1 byte.
- R7: Memory-bound: device bytes accepted on `in_valid`&`in_ready` are written in order, one byte per access (`mem_we`=1), to consecutive physical addresses.
- R8: Device-bound: each byte is read from memory and presented on `out_data` with `out_valid` held until `out_ready`, in logical order.
- R9: At completion the count register becomes zero, `done` pulses for one cycle and `busy` is low in that cycle.
- R10: A memory request keeps `mem_req`, `mem_addr` and `mem_we` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| entry_big_endian | input | 1 | Byte order of table entries |
| start | input | 1 | Transfer request pulse (taken while idle) |
| start_to_mem | input | 1 | 1: device to memory, 0: memory to device |
| start_len | input | 16 | Bytes offered or wanted by the device |
| in_valid | input | 1 | Device byte available |
| in_ready | output | 1 | Engine takes the device byte |
| in_data | input | 8 | Device byte |
| out_valid | output | 1 | Byte for the device is valid |
| out_ready | input | 1 | Device takes the byte |
| out_data | output | 8 | Byte for the device |
| mem_req | output | 1 | Memory request |
| mem_word | output | 1 | 1: 32-bit table-entry read, 0: byte access |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 32 | Read data, lowest address in bits 7:0 |
| mem_ack | input | 1 | Request completed |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |

## Verification
On every cycle, the assertions check that data accesses keep the page offset of the current logical address and stay below the programmed end. They also check that a pending memory request does not change before its acknowledge, that `done` and `err` occur only while idle, and that a completion leaves the count register at zero. The bench's scenarios are the only evidence for the rest: that the right entry is fetched and decoded in both byte orders, that chunk sizes give the expected number of lookups, that the length and count limits stop the transfer at the right byte, and that each byte lands at or comes from the physical address the page table dictates.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    // register indices
    localparam int RG_MODE  = 0;
    localparam int RG_EN    = 1;
    localparam int RG_CNT   = 2;
    localparam int RG_LADDR = 3;
    localparam int RG_TBASE = 4;
    // enable register flag positions
    localparam int EN_RUN   = 0;
    localparam int EN_TODEV = 1;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_GET, S_WR, S_RD, S_PUT
    } eng_st_e;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int RA_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [RA_W-1:0]  addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             clr_cnt,
    output logic [REG_W-1:0] rdata,
    output logic             run_o,
    output logic             todev_o,
    output logic [REG_W-1:0] cnt_o,
    output logic [REG_W-1:0] laddr_o,
    output logic [REG_W-1:0] tbase_o
);
    typedef struct packed {
        logic [REG_W-1:0] mode;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] la;
        logic [REG_W-1:0] tb;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr) begin
            case (addr)
                RA_W'(RG_MODE):  rf_d.mode = wdata;
                RA_W'(RG_EN):    rf_d.en   = wdata;
                RA_W'(RG_CNT):   rf_d.cnt  = wdata;
                RA_W'(RG_LADDR): rf_d.la   = wdata;
                RA_W'(RG_TBASE): rf_d.tb   = wdata;
                default: ;
            endcase
        end
        if (clr_cnt) rf_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        case (addr)
            RA_W'(RG_MODE):  rdata = rf_q.mode;
            RA_W'(RG_EN):    rdata = rf_q.en;
            RA_W'(RG_CNT):   rdata = rf_q.cnt;
            RA_W'(RG_LADDR): rdata = rf_q.la;
            RA_W'(RG_TBASE): rdata = rf_q.tb;
            default:         rdata = '0;
        endcase
    end

    assign run_o   = rf_q.en[EN_RUN];
    assign todev_o = rf_q.en[EN_TODEV];
    assign cnt_o   = rf_q.cnt;
    assign laddr_o = rf_q.la;
    assign tbase_o = rf_q.tb;

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (cnt_o == '0)); // R9
endmodule

// File: rtl/pdma_xlate.sv
module pdma_xlate #(
    parameter int REG_W      = 32,
    parameter int PAGE_W     = 12,
    parameter int ENTRY_LOG2 = 3,
    parameter int SMALL_LOG2 = 4,
    parameter int LARGE_LOG2 = 8,
    localparam int CH_W      = LARGE_LOG2 + 1,
    localparam int NBYTES    = REG_W / 8
) (
    input  logic [REG_W-1:0] la_i,
    input  logic [REG_W-1:0] tbase_i,
    input  logic [REG_W-1:0] raw_i,
    input  logic             big_i,
    input  logic [REG_W:0]   rem_i,
    output logic [REG_W-1:0] entry_addr_o,
    output logic [REG_W-1:0] phys_o,
    output logic [CH_W-1:0]  chunk_o
);
    localparam logic [REG_W-1:0] OFS_MASK = (REG_W'(1) << PAGE_W) - REG_W'(1);
    localparam logic [REG_W:0]   N_SMALL  = (REG_W+1)'(1) << SMALL_LOG2;
    localparam logic [REG_W:0]   N_LARGE  = (REG_W+1)'(1) << LARGE_LOG2;

    logic [REG_W-1:0] swapped;
    logic [REG_W-1:0] entry;

    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign swapped[8*b +: 8] = raw_i[8*(NBYTES-1-b) +: 8];
    end

    always_comb begin
        entry        = big_i ? swapped : raw_i;
        entry_addr_o = tbase_i + ((la_i >> PAGE_W) << ENTRY_LOG2);
        phys_o       = (entry & ~OFS_MASK) | (la_i & OFS_MASK);
        if (phys_o[LARGE_LOG2-1:0] == '0 && rem_i >= N_LARGE)
            chunk_o = CH_W'(1) << LARGE_LOG2;
        else if (phys_o[SMALL_LOG2-1:0] == '0 && rem_i >= N_SMALL)
            chunk_o = CH_W'(1) << SMALL_LOG2;
        else
            chunk_o = CH_W'(1);
    end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int REG_W      = 32,
    parameter int RA_W       = 3,
    parameter int LEN_W      = 16,
    parameter int PAGE_W     = 12,
    parameter int ENTRY_LOG2 = 3,
    parameter int SMALL_LOG2 = 4,
    parameter int LARGE_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             entry_big_endian,
    input  logic             start,
    input  logic             start_to_mem,
    input  logic [LEN_W-1:0] start_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             mem_req,
    output logic             mem_word,
    output logic             mem_we,
    output logic [REG_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [REG_W-1:0] mem_rdata,
    input  logic             mem_ack,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam int CH_W = LARGE_LOG2 + 1;

    typedef struct packed {
        eng_st_e          st;
        logic [REG_W-1:0] la;
        logic [REG_W:0]   lim;
        logic [LEN_W-1:0] left;
        logic             to_mem;
        logic [REG_W-1:0] pa;
        logic [CH_W-1:0]  beats;
        logic [7:0]       byt;
        logic             done;
        logic             err;
    } eng_t;

    eng_t e_d, e_q;

    logic             run, todev, clr_cnt, step;
    logic [REG_W-1:0] cnt, laddr, tbase, entry_addr, phys;
    logic [REG_W:0]   room, rem, la_nx, lim0;
    logic [CH_W-1:0]  chunk;
    logic             more_after;

    pdma_regs #(.REG_W(REG_W), .RA_W(RA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .clr_cnt(clr_cnt), .rdata(reg_rdata),
        .run_o(run), .todev_o(todev), .cnt_o(cnt), .laddr_o(laddr),
        .tbase_o(tbase)
    );

    pdma_xlate #(.REG_W(REG_W), .PAGE_W(PAGE_W), .ENTRY_LOG2(ENTRY_LOG2),
                 .SMALL_LOG2(SMALL_LOG2), .LARGE_LOG2(LARGE_LOG2)) u_xlate (
        .la_i(e_q.la), .tbase_i(tbase), .raw_i(mem_rdata),
        .big_i(entry_big_endian), .rem_i(rem),
        .entry_addr_o(entry_addr), .phys_o(phys), .chunk_o(chunk)
    );

    always_comb begin
        room       = e_q.lim - {1'b0, e_q.la};
        rem        = ({{(REG_W+1-LEN_W){1'b0}}, e_q.left} < room)
                   ? {{(REG_W+1-LEN_W){1'b0}}, e_q.left} : room;
        la_nx      = {1'b0, e_q.la} + (REG_W+1)'(1);
        more_after = (la_nx < e_q.lim) && (e_q.left != LEN_W'(1));
        lim0       = {1'b0, laddr} + {1'b0, cnt};
    end

    always_comb begin
        e_d       = e_q;
        e_d.done  = 1'b0;
        e_d.err   = 1'b0;
        clr_cnt   = 1'b0;
        step      = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        mem_req   = 1'b0;
        mem_word  = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = e_q.pa;
        mem_wdata = e_q.byt;
        case (e_q.st)
            S_IDLE: if (start) begin
                if (!run || (todev == start_to_mem)) begin
                    e_d.err = 1'b1;
                end else begin
                    e_d.la     = laddr;
                    e_d.lim    = lim0;
                    e_d.left   = start_len;
                    e_d.to_mem = start_to_mem;
                    if (({1'b0, laddr} < lim0) && (start_len != '0)) begin
                        e_d.st = S_FETCH;
                    end else begin
                        e_d.done = 1'b1;
                        clr_cnt  = 1'b1;
                    end
                end
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_word = 1'b1;
                mem_addr = entry_addr;
                if (mem_ack) begin
                    e_d.pa    = phys;
                    e_d.beats = chunk;
                    e_d.st    = e_q.to_mem ? S_GET : S_RD;
                end
            end
            S_GET: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    e_d.byt = in_data;
                    e_d.st  = S_WR;
                end
            end
            S_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                step    = mem_ack;
            end
            S_RD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    e_d.byt = mem_rdata[7:0];
                    e_d.st  = S_PUT;
                end
            end
            S_PUT: begin
                out_valid = 1'b1;
                step      = out_ready;
            end
            default: e_d.st = S_IDLE;
        endcase

        if (step) begin
            e_d.la    = la_nx[REG_W-1:0];
            e_d.pa    = e_q.pa + REG_W'(1);
            e_d.left  = e_q.left - LEN_W'(1);
            e_d.beats = e_q.beats - CH_W'(1);
            if (!more_after) begin
                e_d.st   = S_IDLE;
                e_d.done = 1'b1;
                clr_cnt  = 1'b1;
            end else if (e_q.beats == CH_W'(1)) begin
                e_d.st = S_FETCH;
            end else begin
                e_d.st = e_q.to_mem ? S_GET : S_RD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign out_data = e_q.byt;
    assign busy     = (e_q.st != S_IDLE);
    assign done     = e_q.done;
    assign err      = e_q.err;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_DONE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == '0)); // R9
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !mem_req)); // R2
    AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_word) |-> (mem_addr[PAGE_W-1:0] == e_q.la[PAGE_W-1:0])); // R4
    AST_BELOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_word) |-> ({1'b0, e_q.la} < e_q.lim)); // R5
endmodule

// File: tb/tb_pdma_engine.sv
module tb_pdma_engine;
    localparam int CLK_P  = 10;
    localparam int MEM_AW = 15;
    localparam int MEM_N  = 1 << MEM_AW;
    localparam int MAXB   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        big = 1'b0;
    logic        start = 1'b0, start_to_mem = 1'b0;
    logic [15:0] start_len = '0;
    logic        in_valid = 1'b0, in_ready;
    logic [7:0]  in_data;
    logic        out_valid, out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        mem_req, mem_word, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic [7:0]  mem_wdata;
    logic        busy, done, err;

    always #(CLK_P/2) clk = ~clk;

    pdma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .entry_big_endian(big),
        .start(start), .start_to_mem(start_to_mem), .start_len(start_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .mem_req(mem_req), .mem_word(mem_word), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .done(done), .err(err)
    );

    // memory and device models, all in one process
    logic [7:0]  mem [MEM_N];
    logic [7:0]  got [MAXB];
    logic        fill_req = 1'b0, tbl_we = 1'b0, cnt_clr = 1'b0;
    logic [7:0]  fill_seed = '0, dseed = '0, tbl_data = '0;
    logic [MEM_AW-1:0] tbl_addr = '0;
    int          n_ent = 0, n_beats = 0, n_in = 0, n_got = 0, hold_viol = 0;
    logic        pend = 1'b0, pend_we = 1'b0;
    logic [31:0] pend_addr = '0;

    function automatic logic [7:0] pat(int a, logic [7:0] s);
        return 8'((a * 13 + int'(s)) ^ (a >> 8));
    endfunction
    function automatic logic [7:0] dev_byte(int k, logic [7:0] s);
        return 8'(k * 29 + 90 + int'(s));
    endfunction

    assign in_data = dev_byte(n_in, dseed);

    always @(posedge clk) begin
        in_valid  <= ($urandom % 4) != 0;
        out_ready <= ($urandom % 3) != 0;
        if (fill_req) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= pat(i, fill_seed);
        end else if (tbl_we) begin
            mem[tbl_addr] <= tbl_data;
        end
        if (cnt_clr) begin
            n_ent <= 0; n_beats <= 0; n_in <= 0; n_got <= 0;
        end else begin
            if (in_valid && in_ready) n_in <= n_in + 1;
            if (out_valid && out_ready) begin
                if (n_got < MAXB) got[n_got] <= out_data;
                n_got <= n_got + 1;
            end
            if (mem_req && !mem_ack) begin
                if (mem_word) n_ent <= n_ent + 1;
                else          n_beats <= n_beats + 1;
            end
        end
        if (pend && !(mem_req && mem_addr == pend_addr && mem_we == pend_we))
            hold_viol <= hold_viol + 1;
        pend      <= mem_req && !mem_ack;
        pend_addr <= mem_addr;
        pend_we   <= mem_we;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[MEM_AW-1:0]] <= mem_wdata;
            if (mem_word)
                mem_rdata <= {mem[mem_addr[MEM_AW-1:0] + 3], mem[mem_addr[MEM_AW-1:0] + 2],
                              mem[mem_addr[MEM_AW-1:0] + 1], mem[mem_addr[MEM_AW-1:0]]};
            else
                mem_rdata <= {24'h0, mem[mem_addr[MEM_AW-1:0]]};
        end else begin
            mem_ack <= 1'b0;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    // page table: logical pages 0..3 -> distinct physical pages 1..7
    logic [31:0] ent [4];
    int exp_pa [MAXB];
    int exp_n, exp_reads;

    task automatic build_table(input bit be);
        int off;
        off = int'($urandom % 7);
        @(negedge clk); fill_seed = 8'($urandom); fill_req = 1'b1;
        @(negedge clk); fill_req = 1'b0;
        for (int p = 0; p < 4; p++) begin
            ent[p] = (32'(1 + ((p * 2 + off) % 7)) << 12) | 32'($urandom % 4096);
            for (int b = 0; b < 8; b++) begin
                @(negedge clk);
                tbl_we = 1'b1; tbl_addr = MEM_AW'(p * 8 + b);
                if (b >= 4)  tbl_data = 8'hA5;
                else if (be) tbl_data = ent[p][8*(3-b) +: 8];
                else         tbl_data = ent[p][8*b +: 8];
            end
        end
        @(negedge clk); tbl_we = 1'b0;
    endtask

    // reference walk: chunking, lookups and per-byte physical address
    task automatic model(input longint st, input longint cnt, input longint len);
        longint la, lim, i, pa, rem, n;
        la = st; lim = st + cnt; i = 0; exp_reads = 0;
        while (la < lim && i < len) begin
            exp_reads++;
            pa  = (longint'(ent[la >> 12]) & ~longint'(32'hFFF)) | (la & 32'hFFF);
            rem = (len - i < lim - la) ? len - i : lim - la;
            if ((pa % 256) == 0 && rem >= 256)     n = 256;
            else if ((pa % 16) == 0 && rem >= 16)  n = 16;
            else                                   n = 1;
            for (longint j = 0; j < n; j++) exp_pa[i + j] = int'(pa + j);
            la += n; i += n;
        end
        exp_n = int'(i);
    endtask

    task automatic run_xfer(input bit to_mem, input int st, input int cnt,
                            input int len, input bit be, input string tag);
        logic [31:0] rd;
        bit seen;
        int t, bad;
        build_table(be);
        big = be;
        dseed = 8'($urandom);
        reg_write(3, 32'(st));
        reg_write(2, 32'(cnt));
        reg_write(4, 32'h0);
        reg_write(1, to_mem ? 32'h1 : 32'h3);
        model(st, cnt, len);
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        start = 1'b1; start_to_mem = to_mem; start_len = 16'(len);
        @(negedge clk); start = 1'b0;
        seen = done; t = 0;
        while (!seen && t < 20000) begin @(negedge clk); seen = done; t++; end
        chk(seen, "R9", {tag, " done pulse"}, longint'(seen), 1);
        chk(!busy, "R9", {tag, " busy low at done"}, longint'(busy), 0);
        reg_read(2, rd);
        chk(rd == 0, "R9", {tag, " count cleared"}, rd, 0);
        chk(n_ent == exp_reads, "R6", {tag, " table lookups"}, n_ent, exp_reads);
        chk(n_beats == exp_n, "R5", {tag, " bytes moved"}, n_beats, exp_n);
        bad = 0;
        if (to_mem) begin
            chk(n_in == exp_n, "R7", {tag, " device bytes taken"}, n_in, exp_n);
            for (int k = 0; k < exp_n; k++)
                if (mem[exp_pa[k] % MEM_N] != dev_byte(k, dseed)) bad++;
            chk(bad == 0, "R7", {tag, " bytes at translated addresses (R3 R4)"}, bad, 0);
        end else begin
            chk(n_got == exp_n, "R8", {tag, " bytes to device"}, n_got, exp_n);
            for (int k = 0; k < exp_n && k < n_got; k++)
                if (got[k] != pat(exp_pa[k] % MEM_N, fill_seed)) bad++;
            chk(bad == 0, "R8", {tag, " bytes from translated addresses (R3 R4)"}, bad, 0);
        end
    endtask

    task automatic refused(input logic [31:0] en, input bit to_mem, input string tag);
        logic [31:0] rd;
        bit seen;
        reg_write(2, 32'h40);
        reg_write(3, 32'h100);
        reg_write(1, en);
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        start = 1'b1; start_to_mem = to_mem; start_len = 16'd8;
        @(negedge clk); start = 1'b0;
        seen = err;
        chk(!busy, "R2", {tag, " busy stays low"}, longint'(busy), 0);
        repeat (4) @(negedge clk);
        chk(seen, "R2", {tag, " err pulse"}, longint'(seen), 1);
        chk(n_ent + n_beats + n_in + n_got == 0, "R2", {tag, " no movement"},
            n_ent + n_beats + n_in + n_got, 0);
        reg_read(2, rd);
        chk(rd == 32'h40, "R2", {tag, " count unchanged"}, rd, 32'h40);
    endtask

    initial begin
        #(CLK_P * 190000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd, v [5];
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        for (int a = 0; a < 5; a++) begin
            reg_read(a, rd);
            chk(rd == 0, "R1", "reset register value", rd, 0);
        end
        chk(!busy && !done && !err, "R9", "idle after reset", {busy, done, err}, 0);
        // R1: readback
        for (int a = 0; a < 5; a++) begin
            v[a] = $urandom;
            reg_write(a, v[a]);
        end
        for (int a = 0; a < 5; a++) begin
            reg_read(a, rd);
            chk(rd == v[a], "R1", "register readback", rd, v[a]);
        end
        reg_write(5, 32'hFFFF_FFFF);
        reg_read(5, rd);
        chk(rd == 0, "R1", "unused index reads zero", rd, 0);
        // R2: refusals
        refused(32'h0, 1'b1, "run clear");
        refused(32'h3, 1'b1, "to-mem with device-bound flag");
        refused(32'h1, 1'b0, "to-device with memory-bound flag");
        // directed transfers
        run_xfer(1'b1, 32'h0FF0, 32'h40, 32'h100, 1'b0, "page cross");
        run_xfer(1'b0, 32'h1000, 32'h180, 32'h200, 1'b1, "aligned large");
        run_xfer(1'b1, 32'h2005, 32'h100, 3, 1'b1, "length limit");
        run_xfer(1'b0, 32'h3000, 32'h21, 32'h300, 1'b0, "count limit");
        run_xfer(1'b1, 32'h0800, 0, 32'h10, 1'b0, "zero count");
        // random transfers
        for (int r = 0; r < 14; r++)
            run_xfer(1'($urandom), int'($urandom % 32'h3000), int'($urandom % 700),
                     int'($urandom % 700), 1'($urandom), "random");
        chk(hold_viol == 0, "R10", "request held until ack", hold_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule